// File: doc/BRIEF.md
# Instruction Trace Counter

This block sits beside a processor's debug port and gives the debugger single-step and multi-step control. While the core is halted, the debugger loads a step count through the serial debug interface and sets a trace-enable bit. It then issues the leave-debug command. From then on, every instruction the core retires uses up one step. Every instruction counts, including those of a fast interrupt service and each pass of a repeated instruction. When the steps run out, the block pulses a debug-request line toward the core, sets a sticky trace-occurrence flag and raises an acknowledge pulse toward the serial output line.

To stop after N instructions, the count is loaded with N-1. The retire that arrives while the count is already zero is the Nth instruction, and it is the one that triggers the request. The count never wraps below zero. Interrupts are not masked by the block: it only counts retire strobes.

Top module: `trace_step_unit`

## Requirements
- R1: After reset the step count reads 0, and trace enable, trace occurrence, tracing, debug request and acknowledge are all 0.
- R2: A count write loads `cnt_wdata_i` and a count clear sets the count to 0; when both are asserted in the same cycle the clear wins; the new value appears on `cnt_rdata_o` one cycle later.
- R3: `exit_dbg_i` starts tracing (`tracing_o` high on the next cycle) only when trace enable is 1; with trace enable at 0 it has no effect on `tracing_o`.
- R4: While tracing, each retire strobe lowers a nonzero count by exactly 1; while not tracing, retire strobes leave the count unchanged.
- R5: A retire strobe while tracing with a count of 0 makes `dbg_req_o` high for exactly one cycle on the next cycle and ends tracing; the count stays 0 and never wraps. A count loaded with N-1 therefore yields exactly one request, after the Nth retire.
- R6: The request sets `trace_occ_o` on the same cycle; the flag stays set until `occ_clr_i` or reset, and a request in the same cycle as `occ_clr_i` leaves it set.
- R7: `ack_req_o` pulses for one cycle, ACK_STAGES cycles after `dbg_req_o` (one cycle with the default).
- R8: A count write or clear in the same cycle as a retire strobe takes priority: the written value lands, the retire causes neither a decrement nor a request.
- R9: Writing trace enable to 0 while tracing ends tracing; later retire strobes leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_i | input | 1 | Load the step count |
| cnt_clr_i | input | 1 | Clear the step count |
| cnt_wdata_i | input | CNT_W | Value to load |
| cnt_rdata_o | output | CNT_W | Current step count |
| ctl_wr_i | input | 1 | Write the trace-enable bit |
| ctl_en_i | input | 1 | Trace-enable value to write |
| occ_clr_i | input | 1 | Clear the trace-occurrence flag |
| trace_en_o | output | 1 | Trace-enable bit |
| trace_occ_o | output | 1 | Sticky trace-occurrence flag |
| exit_dbg_i | input | 1 | Core leaves debug mode (strobe) |
| retire_i | input | 1 | One instruction retired (strobe) |
| tracing_o | output | 1 | Counting is active |
| dbg_req_o | output | 1 | One-cycle debug-entry request to the core |
| ack_req_o | output | 1 | One-cycle acknowledge request to the serial output |

## Verification
The bench runs traces with step counts of 1, 2 and 3000, with retire strobes that are back-to-back or spaced out. It checks that exactly one request appears, after the Nth strobe. An off-by-one in the zero test would fire one retire early or late. A counter that wraps would keep counting and fire again from the top.

The bench also drives these collisions:
- a count write in the same cycle as a retire, where a wrong design would decrement the fresh value;
- a request in the same cycle as a flag clear, where a wrong design would lose the occurrence;
- retires before the leave-debug command, where a wrong design would count while halted;
- an enable cleared in mid-trace.

A reference model compares every output on every cycle.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

   typedef enum logic {
      TRC_IDLE = 1'b0,
      TRC_RUN  = 1'b1
   } trc_state_e;

   typedef struct packed {
      logic clr;
      logic ld;
   } cnt_cmd_t;

endpackage

// File: rtl/tsu_count.sv
module tsu_count
   import tsu_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_cmd_t         cmd,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             at_zero
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   assign at_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (cmd.clr)
         cnt <= '0;
      else if (cmd.ld)
         cnt <= ld_val;
      else if (dec && !at_zero)
         cnt <= cnt - ONE;
   end

endmodule

// File: rtl/tsu_ctrl.sv
module tsu_ctrl
   import tsu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_busy,
   input  logic en_wr,
   input  logic en_val,
   input  logic exit_dbg,
   input  logic retire,
   input  logic at_zero,
   input  logic occ_clr,
   output logic dec,
   output logic req,
   output logic occ,
   output logic en_q,
   output logic tracing
);

   trc_state_e state_q, state_d;
   logic       step_ok;
   logic       fire;

   assign step_ok = (state_q == TRC_RUN) && en_q && retire && !cmd_busy;
   assign dec     = step_ok && !at_zero;
   assign fire    = step_ok && at_zero;
   assign tracing = (state_q == TRC_RUN);

   always_comb begin
      state_d = state_q;
      if (fire)
         state_d = TRC_IDLE;
      else if (en_wr && !en_val)
         state_d = TRC_IDLE;
      else if (exit_dbg && en_q)
         state_d = TRC_RUN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TRC_IDLE;
         en_q    <= 1'b0;
         occ     <= 1'b0;
         req     <= 1'b0;
      end else begin
         state_q <= state_d;
         req     <= fire;
         if (en_wr)
            en_q <= en_val;
         if (fire)
            occ <= 1'b1;
         else if (occ_clr)
            occ <= 1'b0;
      end
   end

endmodule

// File: rtl/tsu_ack_pipe.sv
module tsu_ack_pipe #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   output logic pulse_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign pulse_o = pulse_i;
      end else begin : g_pipe
         logic [STAGES:0] chain;
         assign chain[0] = pulse_i;
         always_ff @(posedge clk) begin
            if (!rst_n)
               chain[STAGES:1] <= '0;
            else
               chain[STAGES:1] <= chain[STAGES-1:0];
         end
         assign pulse_o = chain[STAGES];
      end
   endgenerate

endmodule

// File: rtl/trace_step_unit.sv
module trace_step_unit
   import tsu_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter int ACK_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_wr_i,
   input  logic             cnt_clr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   output logic [CNT_W-1:0] cnt_rdata_o,
   input  logic             ctl_wr_i,
   input  logic             ctl_en_i,
   input  logic             occ_clr_i,
   output logic             trace_en_o,
   output logic             trace_occ_o,
   input  logic             exit_dbg_i,
   input  logic             retire_i,
   output logic             tracing_o,
   output logic             dbg_req_o,
   output logic             ack_req_o
);

   localparam int MAX_ACK = 3;

   initial begin
      if (CNT_W < 2 || CNT_W > 32)
         $error("trace_step_unit: CNT_W must lie in 2..32");
      if (ACK_STAGES < 0 || ACK_STAGES > MAX_ACK)
         $error("trace_step_unit: ACK_STAGES must lie in 0..3");
   end

   cnt_cmd_t cmd;
   logic     dec, at_zero;

   assign cmd.clr = cnt_clr_i;
   assign cmd.ld  = cnt_wr_i;

   tsu_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .ld_val  (cnt_wdata_i),
      .dec     (dec),
      .cnt     (cnt_rdata_o),
      .at_zero (at_zero)
   );

   tsu_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_busy (cnt_wr_i | cnt_clr_i),
      .en_wr    (ctl_wr_i),
      .en_val   (ctl_en_i),
      .exit_dbg (exit_dbg_i),
      .retire   (retire_i),
      .at_zero  (at_zero),
      .occ_clr  (occ_clr_i),
      .dec      (dec),
      .req      (dbg_req_o),
      .occ      (trace_occ_o),
      .en_q     (trace_en_o),
      .tracing  (tracing_o)
   );

   tsu_ack_pipe #(.STAGES(ACK_STAGES)) u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_i (dbg_req_o),
      .pulse_o (ack_req_o)
   );

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
   parameter int CNT_W      = 24,
   parameter int ACK_STAGES = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_wr_i,
   input logic             cnt_clr_i,
   input logic [CNT_W-1:0] cnt_rdata_o,
   input logic             ctl_wr_i,
   input logic             occ_clr_i,
   input logic             trace_en_o,
   input logic             trace_occ_o,
   input logic             retire_i,
   input logic             tracing_o,
   input logic             dbg_req_o,
   input logic             ack_req_o
);

   // R5
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_o |=> !dbg_req_o);

   // R5
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rdata_o == '0 && !cnt_wr_i) |=> (cnt_rdata_o == '0));

   // R6
   occ_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_occ_o && !occ_clr_i) |=> trace_occ_o);

   // R6
   req_sets_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_o |-> trace_occ_o);

   // R4
   step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tracing_o && trace_en_o && retire_i && !cnt_wr_i && !cnt_clr_i && cnt_rdata_o != '0)
      |=> (cnt_rdata_o == $past(cnt_rdata_o) - 1'b1));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tracing_o && !cnt_wr_i && !cnt_clr_i) |=> $stable(cnt_rdata_o));

   // R9
   disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && !trace_en_o && !tracing_o) |=> !tracing_o);

   generate
      if (ACK_STAGES == 0) begin : g_ack0
         // R7
         ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dbg_req_o |-> ack_req_o);
      end else begin : g_ackn
         // R7
         ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dbg_req_o |=> ##(ACK_STAGES-1) ack_req_o);
      end
   endgenerate

endmodule

bind trace_step_unit tsu_checker #(.CNT_W(CNT_W), .ACK_STAGES(ACK_STAGES)) u_chk (.*);

// File: tb/trace_step_unit_tb.sv
module trace_step_unit_tb;

   localparam int W = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_wr = 0, cnt_clr = 0, ctl_wr = 0, ctl_en = 0, occ_clr = 0;
   logic         exit_dbg = 0, retire = 0;
   logic [W-1:0] cnt_wdata = '0;
   logic [W-1:0] cnt_rdata;
   logic         trace_en, trace_occ, tracing, dbg_req, ack_req;

   int tests = 0, fails = 0, cyc = 0;
   int m_cnt = 0, m_en = 0, m_occ = 0, m_trc = 0, m_req = 0, m_ack = 0;

   always #5 clk = ~clk;

   trace_step_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .cnt_wr_i(cnt_wr), .cnt_clr_i(cnt_clr), .cnt_wdata_i(cnt_wdata), .cnt_rdata_o(cnt_rdata),
      .ctl_wr_i(ctl_wr), .ctl_en_i(ctl_en), .occ_clr_i(occ_clr),
      .trace_en_o(trace_en), .trace_occ_o(trace_occ),
      .exit_dbg_i(exit_dbg), .retire_i(retire),
      .tracing_o(tracing), .dbg_req_o(dbg_req), .ack_req_o(ack_req)
   );

   // behavioural reference, one update per rising edge
   always @(posedge clk) begin
      int fire;
      cyc++;
      if (!rst_n) begin
         m_cnt = 0; m_en = 0; m_occ = 0; m_trc = 0; m_req = 0; m_ack = 0;
      end else begin
         fire  = (m_trc && m_en && retire && m_cnt == 0 && !cnt_wr && !cnt_clr) ? 1 : 0;
         m_ack = m_req;
         m_req = fire;
         if (m_trc && m_en && retire && m_cnt > 0 && !cnt_wr && !cnt_clr) m_cnt = m_cnt - 1;
         if (cnt_clr) m_cnt = 0;
         else if (cnt_wr) m_cnt = int'(cnt_wdata);
         if (fire) m_trc = 0;
         else if (ctl_wr && !ctl_en) m_trc = 0;
         else if (exit_dbg && m_en) m_trc = 1;
         if (ctl_wr) m_en = int'(ctl_en);
         if (fire) m_occ = 1;
         else if (occ_clr) m_occ = 0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         check(int'(cnt_rdata) == m_cnt, "R2/R4 model count", int'(cnt_rdata), m_cnt);
         check({trace_en, trace_occ, tracing, dbg_req, ack_req} ==
               {m_en[0], m_occ[0], m_trc[0], m_req[0], m_ack[0]}, "R3/R5/R6/R7 model flags",
               int'({trace_en, trace_occ, tracing, dbg_req, ack_req}),
               int'({m_en[0], m_occ[0], m_trc[0], m_req[0], m_ack[0]}));
      end
   end

   task automatic step;
      @(negedge clk);
   endtask

   task automatic run_trace(input int n, input int gap, input bit clr_on_fire);
      int early = 0;
      cnt_wr = 1; cnt_wdata = W'(n - 1); ctl_wr = 1; ctl_en = 1;
      step();
      cnt_wr = 0; ctl_wr = 0;
      // retires before leaving debug mode must not count (R4)
      retire = 1; step(); retire = 0;
      check(int'(cnt_rdata) == n - 1, "R4 halted retire ignored", int'(cnt_rdata), n - 1);
      exit_dbg = 1; step(); exit_dbg = 0;
      check(tracing == 1'b1, "R3 exit starts tracing", int'(tracing), 1);
      for (int i = 0; i < n; i++) begin
         retire = 1;
         if (i == n - 1) occ_clr = clr_on_fire;
         step();
         retire = 0; occ_clr = 0;
         if (i < n - 1) begin
            if (dbg_req) early++;
            if (gap != 0 && (i % gap) == 0) step();
         end
      end
      check(early == 0, "R5 no early request", early, 0);
      check(dbg_req == 1'b1, "R5 request after Nth retire", int'(dbg_req), 1);
      check(trace_occ == 1'b1, "R6 occurrence set", int'(trace_occ), 1);
      check(tracing == 1'b0, "R5 tracing ends", int'(tracing), 0);
      step();
      check(dbg_req == 1'b0, "R5 single-cycle request", int'(dbg_req), 0);
      check(ack_req == 1'b1, "R7 acknowledge one cycle later", int'(ack_req), 1);
      retire = 1; step(); retire = 0;
      check(int'(cnt_rdata) == 0 && !dbg_req, "R5 no wrap after zero", int'(cnt_rdata), 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) step();
            rst_n = 1;
            step();
            check({cnt_rdata, trace_en, trace_occ, tracing, dbg_req, ack_req} == '0,
                  "R1 reset state", int'(cnt_rdata), 0);

            cnt_wr = 1; cnt_wdata = 24'hFFFFFF; step(); cnt_wr = 0;
            check(cnt_rdata == 24'hFFFFFF, "R2 load max", int'(cnt_rdata), 24'hFFFFFF);
            cnt_wr = 1; cnt_clr = 1; cnt_wdata = 24'd77; step(); cnt_wr = 0; cnt_clr = 0;
            check(cnt_rdata == 0, "R2 clear beats load", int'(cnt_rdata), 0);

            exit_dbg = 1; step(); exit_dbg = 0;
            check(tracing == 1'b0, "R3 exit with enable off", int'(tracing), 0);

            run_trace(1, 0, 0);
            run_trace(2, 0, 1);
            check(trace_occ == 1'b1, "R6 fire beats clear", int'(trace_occ), 1);
            occ_clr = 1; step(); occ_clr = 0;
            check(trace_occ == 1'b0, "R6 clear works", int'(trace_occ), 0);
            run_trace(3000, 3, 0);

            // R8: write collides with retire
            cnt_wr = 1; cnt_wdata = 24'd10; step(); cnt_wr = 0;
            exit_dbg = 1; step(); exit_dbg = 0;
            retire = 1; cnt_wr = 1; cnt_wdata = 24'd40; step(); retire = 0; cnt_wr = 0;
            check(cnt_rdata == 24'd40, "R8 write beats retire", int'(cnt_rdata), 40);
            cnt_clr = 1; retire = 1; step(); cnt_clr = 0; retire = 0;
            check(cnt_rdata == 0 && !dbg_req, "R8 clear with retire no request", int'(dbg_req), 0);
            cnt_wr = 1; cnt_wdata = 24'd5; step(); cnt_wr = 0;
            retire = 1; step(); retire = 0;
            check(cnt_rdata == 24'd4, "R4 decrement while tracing", int'(cnt_rdata), 4);

            // R9: disable mid-trace
            ctl_wr = 1; ctl_en = 0; step(); ctl_wr = 0;
            check(tracing == 1'b0, "R9 disable ends tracing", int'(tracing), 0);
            retire = 1; repeat (3) step(); retire = 0;
            check(cnt_rdata == 24'd4, "R9 count frozen", int'(cnt_rdata), 4);
            step();
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog", cyc, 20000);
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule